// File: doc/BRIEF.md
# Single-Precision Floating-Point Compare Unit

This block orders two single-precision binary floating-point operands and leaves the answer as four condition flags: less-than, equal, greater-than and unordered. A conditional branch stage reads these flags. The comparison is done on the packed word as an unsigned integer comparison of the 31 magnitude bits below the sign, because the biased exponent sits above the fraction. Fix-up logic then corrects the result for the sign, for the two encodings of zero and for not-a-number operands.

A caller presents both operands together with a one-cycle `cmp_valid` strobe. On the next clock edge the flags load the outcome. They keep that outcome until the next strobe, so a branch issued any number of cycles later still reads the result of the most recent compare.

Top module: `fpc_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first compare, all four flags are 0.
- R2: The flags load a new result on the clock edge where `cmp_valid` is sampled high. They stay unchanged on every edge where it is sampled low, whatever the operands do.
- R3: After any compare, exactly one of `flag_lt`, `flag_eq`, `flag_gt`, `flag_unord` is 1.
- R4: An operand is a NaN when bits 30..23 are all ones and bits 22..0 are not all zero. If either operand is a NaN, `flag_unord` is 1 and the other three flags are 0.
- R5: The encodings 0x00000000 (+0) and 0x80000000 (-0) compare equal in every pairing.
- R6: If both operands have sign bit 31 clear and neither is a NaN, the order follows the unsigned value of bits 30..0 (exponent in bits 30..23, biased by 127, above the fraction).
- R7: If both operands have sign bit 31 set and neither is a NaN, the order is the reverse of the unsigned order of bits 30..0.
- R8: If the sign bits differ, neither operand is a NaN and the two are not both zero, the operand whose sign bit is set is the smaller one.
- R9: Infinities (bits 30..23 all ones, bits 22..0 zero) order as extremes. +inf is greater than every finite value, -inf is less than every finite value, and an infinity equals the infinity of the same sign.
- R10: Two identical bit patterns that are not a NaN compare equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Starts a compare of the present operands |
| opnd_a | input | 32 | Left operand (a in "a < b") |
| opnd_b | input | 32 | Right operand |
| flag_lt | output | 1 | a is less than b |
| flag_eq | output | 1 | a equals b |
| flag_gt | output | 1 | a is greater than b |
| flag_unord | output | 1 | At least one operand is a NaN |

## Verification
Several properties are checked on every cycle. Exactly one flag is set after each strobe, and the flags hold between strobes. A NaN operand forces the unordered result, zero pairs and identical patterns give equal, and mixed-sign pairs favour the positive operand. Other behaviour depends on the exact operand values and can only be shown by the bench's scenarios: the inversion of order for two negative operands, the extreme placement of infinities, the ordering of subnormals against normals, and the reset value of the flags. The bench covers these with directed pairs and with random pairs drawn to hit special encodings often.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int MAG_W   = EXP_W + FRAC_W;
    localparam int WORD_W  = MAG_W + 1;
    localparam int CHUNK_W = 8;
    localparam int N_CHUNK = (MAG_W + CHUNK_W - 1) / CHUNK_W;
    localparam int PAD_W   = N_CHUNK * CHUNK_W;

    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_zero;
        logic [MAG_W-1:0] mag;
    } opnd_info_t;

    typedef enum logic [1:0] {
        ORD_LT = 2'd0,
        ORD_EQ = 2'd1,
        ORD_GT = 2'd2
    } mag_ord_t;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
        logic un;
    } cc_t;

    typedef struct packed {
        cc_t cc;
    } fpc_state_t;
endpackage

// File: rtl/fpc_classify.sv
module fpc_classify
    import fpc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output opnd_info_t        info
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;

    always_comb begin
        exp_f    = word[WORD_W-2 -: EXP_W];
        frac_f   = word[FRAC_W-1:0];
        exp_ones = &exp_f;

        info.sign    = word[WORD_W-1];
        info.mag     = word[MAG_W-1:0];
        info.is_nan  = exp_ones && (|frac_f);
        info.is_zero = ~|word[MAG_W-1:0];
    end
endmodule

// File: rtl/fpc_mag_order.sv
module fpc_mag_order
    import fpc_pkg::*;
(
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output mag_ord_t         ord
);
    logic [PAD_W-1:0]   pad_a;
    logic [PAD_W-1:0]   pad_b;
    logic [N_CHUNK-1:0] ch_lt;
    logic [N_CHUNK-1:0] ch_eq;

    assign pad_a = {{(PAD_W-MAG_W){1'b0}}, mag_a};
    assign pad_b = {{(PAD_W-MAG_W){1'b0}}, mag_b};

    // Per-slice compares, resolved from the most significant slice down.
    for (genvar g = 0; g < N_CHUNK; g++) begin : g_slice
        logic [CHUNK_W-1:0] sa;
        logic [CHUNK_W-1:0] sb;
        assign sa       = pad_a[g*CHUNK_W +: CHUNK_W];
        assign sb       = pad_b[g*CHUNK_W +: CHUNK_W];
        assign ch_lt[g] = (sa < sb);
        assign ch_eq[g] = (sa == sb);
    end

    always_comb begin
        logic decided;
        decided = 1'b0;
        ord     = ORD_EQ;
        for (int i = N_CHUNK - 1; i >= 0; i--) begin
            if (!decided && !ch_eq[i]) begin
                decided = 1'b1;
                ord     = ch_lt[i] ? ORD_LT : ORD_GT;
            end
        end
    end
endmodule

// File: rtl/fpc_resolve.sv
module fpc_resolve
    import fpc_pkg::*;
(
    input  opnd_info_t info_a,
    input  opnd_info_t info_b,
    input  mag_ord_t   ord,
    output cc_t        cc
);
    always_comb begin
        cc = '0;
        if (info_a.is_nan || info_b.is_nan) begin
            cc.un = 1'b1;
        end else if (info_a.is_zero && info_b.is_zero) begin
            cc.eq = 1'b1;
        end else if (info_a.sign != info_b.sign) begin
            cc.lt = info_a.sign;
            cc.gt = info_b.sign;
        end else if (ord == ORD_EQ) begin
            cc.eq = 1'b1;
        end else if (!info_a.sign) begin
            cc.lt = (ord == ORD_LT);
            cc.gt = (ord == ORD_GT);
        end else begin
            cc.lt = (ord == ORD_GT);
            cc.gt = (ord == ORD_LT);
        end
    end
endmodule

// File: rtl/fpc_unit.sv
module fpc_unit
    import fpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    output logic              flag_lt,
    output logic              flag_eq,
    output logic              flag_gt,
    output logic              flag_unord
);
    opnd_info_t info [2];
    mag_ord_t   ord;
    cc_t        cc_new;
    fpc_state_t st_d;
    fpc_state_t st_q;

    for (genvar k = 0; k < 2; k++) begin : g_cls
        fpc_classify u_cls (
            .word (k == 0 ? opnd_a : opnd_b),
            .info (info[k])
        );
    end

    fpc_mag_order u_ord (
        .mag_a (info[0].mag),
        .mag_b (info[1].mag),
        .ord   (ord)
    );

    fpc_resolve u_res (
        .info_a (info[0]),
        .info_b (info[1]),
        .ord    (ord),
        .cc     (cc_new)
    );

    always_comb begin
        st_d = st_q;
        if (cmp_valid) begin
            st_d.cc = cc_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_lt    = st_q.cc.lt;
    assign flag_eq    = st_q.cc.eq;
    assign flag_gt    = st_q.cc.gt;
    assign flag_unord = st_q.cc.un;
endmodule

// File: rtl/fpc_unit_chk.sv
module fpc_unit_chk
    import fpc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_valid,
    input logic [WORD_W-1:0] opnd_a,
    input logic [WORD_W-1:0] opnd_b,
    input logic              flag_lt,
    input logic              flag_eq,
    input logic              flag_gt,
    input logic              flag_unord
);
    logic armed_q;
    logic a_nan;
    logic b_nan;
    logic both_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign a_nan     = (&opnd_a[WORD_W-2 -: EXP_W]) && (|opnd_a[FRAC_W-1:0]);
    assign b_nan     = (&opnd_b[WORD_W-2 -: EXP_W]) && (|opnd_b[FRAC_W-1:0]);
    assign both_zero = (opnd_a[MAG_W-1:0] == '0) && (opnd_b[MAG_W-1:0] == '0);

    // R3
    onehot_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(cmp_valid)) |->
            $countones({flag_lt, flag_eq, flag_gt, flag_unord}) == 1);

    // R2
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(cmp_valid)) |->
            $stable({flag_lt, flag_eq, flag_gt, flag_unord}));

    // R4
    nan_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(cmp_valid && (a_nan || b_nan))) |->
            (flag_unord && !flag_lt && !flag_eq && !flag_gt));

    // R5
    zero_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(cmp_valid && both_zero)) |-> flag_eq);

    // R10
    same_word_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(cmp_valid && (opnd_a == opnd_b) && !a_nan)) |-> flag_eq);

    // R8
    sign_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(cmp_valid && (opnd_a[WORD_W-1] != opnd_b[WORD_W-1])
                          && !a_nan && !b_nan && !both_zero)) |->
            (flag_lt == $past(opnd_a[WORD_W-1]) && flag_gt == $past(opnd_b[WORD_W-1])));
endmodule

bind fpc_unit fpc_unit_chk u_chk (.*);

// File: tb/sim_fpc_unit.sv
module sim_fpc_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        flag_lt, flag_eq, flag_gt, flag_unord;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpc_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .flag_lt(flag_lt), .flag_eq(flag_eq), .flag_gt(flag_gt), .flag_unord(flag_unord)
    );

    function automatic bit is_nan(input logic [31:0] w);
        return (w[30:23] == 8'hFF) && (w[22:0] != 0);
    endfunction

    // Expected flags {lt, eq, gt, unord} from signed magnitude keys.
    function automatic logic [3:0] expect_cc(input logic [31:0] a, input logic [31:0] b);
        longint ka, kb;
        if (is_nan(a) || is_nan(b)) return 4'b0001;
        ka = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
        kb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
        if (ka < kb) return 4'b1000;
        if (ka > kb) return 4'b0010;
        return 4'b0100;
    endfunction

    function automatic string req_of(input logic [31:0] a, input logic [31:0] b);
        if (is_nan(a) || is_nan(b))               return "R4";
        if (a[30:0] == 0 && b[30:0] == 0)          return "R5";
        if (a == b)                                return "R10";
        if (a[30:0] == 31'h7F80_0000 || b[30:0] == 31'h7F80_0000) return "R9";
        if (a[31] != b[31])                        return "R8";
        if (a[31])                                 return "R7";
        return "R6";
    endfunction

    task automatic check_flags(input logic [3:0] exp_cc, input string req);
        logic [3:0] got;
        got = {flag_lt, flag_eq, flag_gt, flag_unord};
        n_checks++;
        if (got !== exp_cc) begin
            n_fails++;
            $display("FAIL %s a=%h b=%h flags(lt,eq,gt,un) got=%b exp=%b",
                     req, opnd_a, opnd_b, got, exp_cc);
        end
    endtask

    task automatic do_cmp(input logic [31:0] a, input logic [31:0] b, input string req);
        @(negedge clk);
        opnd_a    = a;
        opnd_b    = b;
        cmp_valid = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0;
        check_flags(expect_cc(a, b), req);
    endtask

    function automatic logic [31:0] pick_operand();
        int sel;
        sel = int'($urandom_range(0, 11));
        case (sel)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return {$urandom_range(0, 1) == 1, 31'h7F80_0000};
            3: return {$urandom_range(0, 1) == 1, 8'hFF, 23'($urandom_range(1, 32'h7F_FFFF))};
            4: return {$urandom_range(0, 1) == 1, 8'h00, 23'($urandom)};
            5: return {$urandom_range(0, 1) == 1, 31'h7F7F_FFFF};
            6: return {$urandom_range(0, 1) == 1, 8'($urandom_range(120, 134)), 23'($urandom)};
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        void'($urandom(32'h0C0F_FEE5));

        // R1: reset state, during and after release
        repeat (3) @(negedge clk);
        check_flags(4'b0000, "R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_flags(4'b0000, "R1");

        // R5: signed zeros
        do_cmp(32'h0000_0000, 32'h8000_0000, "R5");
        do_cmp(32'h8000_0000, 32'h0000_0000, "R5");
        do_cmp(32'h8000_0000, 32'h8000_0000, "R5");
        // R6: positive ordering (1.0 vs 2.0, 0.5 vs 1.0, subnormal vs min normal)
        do_cmp(32'h3F80_0000, 32'h4000_0000, "R6");
        do_cmp(32'h3F80_0000, 32'h3F00_0000, "R6");
        do_cmp(32'h0000_0001, 32'h0080_0000, "R6");
        // R7: negative ordering (-1.0 vs -2.0, -5.0 vs -0.75)
        do_cmp(32'hBF80_0000, 32'hC000_0000, "R7");
        do_cmp(32'hC0A0_0000, 32'hBF40_0000, "R7");
        // R8: mixed signs, including zero against tiny negative
        do_cmp(32'hBF40_0000, 32'h3F80_0000, "R8");
        do_cmp(32'h0000_0000, 32'h8000_0001, "R8");
        do_cmp(32'h8000_0001, 32'h0000_0000, "R8");
        // R9: infinities
        do_cmp(32'h7F80_0000, 32'h7F7F_FFFF, "R9");
        do_cmp(32'hFF80_0000, 32'hFF7F_FFFF, "R9");
        do_cmp(32'h7F80_0000, 32'h7F80_0000, "R9");
        do_cmp(32'hFF80_0000, 32'h7F80_0000, "R9");
        // R4: NaNs
        do_cmp(32'h7FC0_0000, 32'h3F80_0000, "R4");
        do_cmp(32'h0000_0000, 32'hFF80_0001, "R4");
        do_cmp(32'h7FC0_0000, 32'h7FC0_0000, "R4");
        // R10: identical patterns
        do_cmp(32'hC0A0_0000, 32'hC0A0_0000, "R10");

        // R2: operands change with no strobe; flags keep previous result (eq)
        @(negedge clk);
        opnd_a = 32'h7FC0_0000;
        opnd_b = 32'h0000_0001;
        repeat (3) @(negedge clk);
        check_flags(4'b0100, "R2");

        // R3 and all orderings: random pairs
        for (int i = 0; i < N_RANDOM; i++) begin
            a = pick_operand();
            case ($urandom_range(0, 3))
                0: b = a;
                1: b = a ^ (32'h1 << $urandom_range(0, 31));
                default: b = pick_operand();
            endcase
            do_cmp(a, b, req_of(a, b));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule